// File: doc/BRIEF.md
# Condition Code Evaluator with Flag Generator

This block decides whether an instruction carrying a 4-bit condition field may execute. It compares that field against four stored status flags: negative, zero, carry and overflow. It also derives a fresh set of those flags from a 32-bit add or subtract that the surrounding datapath has already computed. The pass/skip decision is combinational and is based on the flags held at that moment. A flag-setting instruction that passes writes the newly derived flags into the flag register at the next rising clock edge.

The block has three parts:
- A flag generator looks at both operands, the result, the adder's carry-or-borrow output and an add/subtract select.
- A condition evaluator groups the sixteen codes into eight predicates. The low bit of the code selects the predicate itself or its complement.
- A small register holds the flags. It has two named behaviours. In HOLD, the flags are kept when no update is requested or when the instruction is skipped. In LOAD, the flags are replaced.

The evaluator's predicate groups are named ZERO, CARRY, NEG, OVF, HIGHER, GE, GT and ALWAYS.

Top module: `ccx_core`

## Requirements
- R1: While `rst_n` is low, and after reset, `flags_q` reads 4'b0000. The layout is {N,Z,C,V} at bits 3..0.
- R2: Single-flag codes evaluate as follows:
  - 0000 passes when Z=1.
  - 0001 passes when Z=0.
  - 0010 passes when C=1.
  - 0011 passes when C=0.
  - 0100 passes when N=1.
  - 0101 passes when N=0.
  - 0110 passes when V=1.
  - 0111 passes when V=0.
- R3: Unsigned compound codes evaluate as follows:
  - 1000 (higher) passes when C=1 and Z=0.
  - 1001 (lower or same) passes when C=0 or Z=1.
- R4: Signed compound codes evaluate as follows:
  - 1010 passes when N equals V.
  - 1011 passes when N differs from V.
  - 1100 passes when Z=0 and N equals V.
  - 1101 passes when Z=1 or N differs from V.
- R5: Code 1110 always passes and code 1111 never passes, whatever the flags.
- R6: The derived N is bit 31 of `result`. The derived Z is 1 exactly when `result` is all zeros.
- R7: For an add (`op_sub`=0), the derived C equals `carry_borrow`, the carry out. For a subtract (`op_sub`=1), `carry_borrow` is the borrow and C is its inverse, so C=1 when no borrow occurs.
- R8: The derived V is 1 when the operation overflows in signed arithmetic:
  - For an add, when the operands share a sign that the result lacks.
  - For a subtract, when the operands' signs differ and the result's sign differs from `opa`.
- R9: The flag register loads the derived flags at the next rising edge only when `set_req`=1 and `exec_ok`=1. Otherwise `flags_q` is unchanged.
- R10: `exec_ok` reflects `cond` and the current `flags_q` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond | input | 4 | Condition field of the current instruction |
| set_req | input | 1 | Instruction asks to update the flags |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | input | 32 | Result of the add or subtract |
| carry_borrow | input | 1 | Adder carry out (add) or borrow out (subtract) |
| exec_ok | output | 1 | 1 = execute, 0 = skip |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions check several things on every cycle:
- HOLD and LOAD of the flag register.
- The fixed outcomes of codes 1110 and 1111.
- The zero-result flag pattern.
- Agreement between the zero-equal code and the stored Z bit.

Only the bench's scenarios can show that each of the sixteen codes gives the right answer against every flag combination. The same holds for the carry and overflow corners of add and subtract: 0x7FFFFFFF+1, 0x80000000-1, 0-0 and 0-1. These scenarios also show that a skipped flag-setting instruction leaves the flags unchanged.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

    localparam int CCX_DATA_W = 32;
    localparam int CCX_COND_W = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } ccx_flags_t;

    // Predicate groups: cond[3:1]; cond[0] selects the complement
    typedef enum logic [2:0] {
        PR_ZERO   = 3'd0,
        PR_CARRY  = 3'd1,
        PR_NEG    = 3'd2,
        PR_OVF    = 3'd3,
        PR_HIGHER = 3'd4,
        PR_GE     = 3'd5,
        PR_GT     = 3'd6,
        PR_ALWAYS = 3'd7
    } ccx_pred_e;

    // Flag register behaviour
    typedef enum logic {
        FR_HOLD = 1'b0,
        FR_LOAD = 1'b1
    } ccx_freg_e;

endpackage

// File: rtl/ccx_flag_gen.sv
module ccx_flag_gen
    import ccx_pkg::*;
#(
    parameter int DATA_W = CCX_DATA_W
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_borrow,
    input  logic              op_sub,
    output ccx_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    logic sa, sb, sr;
    logic same_sign, res_flip;

    always_comb begin
        sa        = opa[MSB];
        sb        = opb[MSB];
        sr        = result[MSB];
        same_sign = ~(sa ^ sb);
        res_flip  = sa ^ sr;

        flags.n = sr;
        flags.z = ~|result;
        if (op_sub) begin
            // borrow in, carry flag is its inverse (R7)
            flags.c = ~carry_borrow;
            flags.v = ~same_sign & res_flip;
        end else begin
            flags.c = carry_borrow;
            flags.v = same_sign & res_flip;
        end
    end

endmodule

// File: rtl/ccx_cond_eval.sv
module ccx_cond_eval
    import ccx_pkg::*;
#(
    parameter int COND_W = CCX_COND_W
) (
    input  logic [COND_W-1:0] cond,
    input  ccx_flags_t        flags,
    output logic              pass
);
    ccx_pred_e pred;
    logic      base;
    logic      n_eq_v;

    always_comb begin
        pred   = ccx_pred_e'(cond[COND_W-1:1]);
        n_eq_v = ~(flags.n ^ flags.v);
        unique case (pred)
            PR_ZERO:   base = flags.z;
            PR_CARRY:  base = flags.c;
            PR_NEG:    base = flags.n;
            PR_OVF:    base = flags.v;
            PR_HIGHER: base = flags.c & ~flags.z;
            PR_GE:     base = n_eq_v;
            PR_GT:     base = ~flags.z & n_eq_v;
            PR_ALWAYS: base = 1'b1;
            default:   base = 1'b0;
        endcase
        // odd code = complement (covers 1111 as never)
        pass = base ^ cond[0];
    end

endmodule

// File: rtl/ccx_flag_reg.sv
module ccx_flag_reg
    import ccx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  ccx_flags_t d,
    output ccx_flags_t q
);
    ccx_freg_e  mode;
    ccx_flags_t q_next;

    always_comb begin
        mode = wr_en ? FR_LOAD : FR_HOLD;
    end

    always_comb begin
        unique case (mode)
            FR_LOAD: q_next = d;
            FR_HOLD: q_next = q;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/ccx_core.sv
module ccx_core
    import ccx_pkg::*;
#(
    parameter int DATA_W = CCX_DATA_W,
    parameter int COND_W = CCX_COND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] cond,
    input  logic              set_req,
    input  logic              op_sub,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_borrow,
    output logic              exec_ok,
    output logic [3:0]        flags_q
);
    ccx_flags_t gen_flags;
    ccx_flags_t cur_flags;
    logic       wr_en;

    ccx_flag_gen #(.DATA_W(DATA_W)) u_gen (
        .opa          (opa),
        .opb          (opb),
        .result       (result),
        .carry_borrow (carry_borrow),
        .op_sub       (op_sub),
        .flags        (gen_flags)
    );

    ccx_cond_eval #(.COND_W(COND_W)) u_eval (
        .cond  (cond),
        .flags (cur_flags),
        .pass  (exec_ok)
    );

    assign wr_en = set_req & exec_ok;

    ccx_flag_reg u_freg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .d     (gen_flags),
        .q     (cur_flags)
    );

    assign flags_q = cur_flags;

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && exec_ok) |=> (flags_q == $past(gen_flags)));

    p_skip_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_req && exec_ok) |=> $stable(flags_q));

    p_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hE) |-> exec_ok);

    p_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hF) |-> !exec_ok);

    p_eq_follows_z_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'h0) |-> (exec_ok == flags_q[2]));

    p_zero_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && exec_ok && result == '0) |=> (flags_q[2] && !flags_q[3]));

endmodule

// File: tb/ccx_core_tb.sv
module ccx_core_tb;

    localparam real CLK_NS = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond = 4'hE;
    logic        set_req = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result = '0;
    logic        carry_borrow = 1'b0;
    logic        exec_ok;
    logic [3:0]  flags_q;

    int checks = 0;
    int fails  = 0;

    logic [3:0] mflags = 4'b0000;
    bit         last_upd = 1'b0;

    always #(CLK_NS/2.0) clk = ~clk;

    ccx_core u_dut (
        .clk(clk), .rst_n(rst_n), .cond(cond), .set_req(set_req),
        .op_sub(op_sub), .opa(opa), .opb(opb), .result(result),
        .carry_borrow(carry_borrow), .exec_ok(exec_ok), .flags_q(flags_q)
    );

    function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string cond_tag(input logic [3:0] c);
        if (c < 4'h8)  return "R2/R10";
        if (c < 4'hA)  return "R3/R10";
        if (c < 4'hE)  return "R4/R10";
        return "R5/R10";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_flags();
        if (last_upd) begin
            check("R6 N", {31'b0, flags_q[3]}, {31'b0, mflags[3]});
            check("R6 Z", {31'b0, flags_q[2]}, {31'b0, mflags[2]});
            check("R7 C", {31'b0, flags_q[1]}, {31'b0, mflags[1]});
            check("R8 V", {31'b0, flags_q[0]}, {31'b0, mflags[0]});
        end else begin
            check("R9 hold", {28'b0, flags_q}, {28'b0, mflags});
        end
    endtask

    task automatic step(input logic [3:0] c, input bit set, input bit sub,
                        input logic [31:0] a, input logic [31:0] b);
        logic [32:0] full;
        longint      sa, sb, sv;
        bit          exp_pass, cb, cexp, vexp;
        logic [31:0] r;
        @(negedge clk);
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (sub) begin
            full = {1'b0, a} - {1'b0, b};
            cb   = full[32];
            cexp = (a >= b);
            sv   = sa - sb;
        end else begin
            full = {1'b0, a} + {1'b0, b};
            cb   = full[32];
            cexp = full[32];
            sv   = sa + sb;
        end
        r    = full[31:0];
        vexp = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        cond = c; set_req = set; op_sub = sub; opa = a; opb = b;
        result = r; carry_borrow = cb;
        #1;
        check_flags();
        exp_pass = ref_pass(c, mflags);
        check(cond_tag(c), {31'b0, exec_ok}, {31'b0, exp_pass});
        @(posedge clk);
        if (set && exp_pass) begin
            mflags   = {r[31], (r == 32'h0), cexp, vexp};
            last_upd = 1'b1;
        end else begin
            last_upd = 1'b0;
        end
    endtask

    task automatic sweep_conds();
        for (int k = 0; k < 16; k++) step(4'(k), 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {28'b0, flags_q}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after reset", {28'b0, flags_q}, 32'h0);

        sweep_conds();
        // corner cases, each followed by a full sweep without update
        step(4'hE, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h1);   // N=1 V=1
        sweep_conds();
        step(4'hE, 1'b1, 1'b1, 32'h8000_0000, 32'h1);   // V=1 C=1
        sweep_conds();
        step(4'hE, 1'b1, 1'b1, 32'h0, 32'h0);           // Z=1 C=1
        sweep_conds();
        step(4'hE, 1'b1, 1'b1, 32'h0, 32'h1);           // N=1 C=0 (borrow)
        sweep_conds();
        step(4'hE, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1);   // Z=1 C=1
        sweep_conds();
        step(4'hE, 1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000); // Z C V
        sweep_conds();
        // skipped flag-setting instruction must not update (R9)
        step(4'hF, 1'b1, 1'b0, 32'h1, 32'h1);
        step(4'hE, 1'b0, 1'b0, 32'h0, 32'h0);
        // randomised traffic
        for (int i = 0; i < 3000; i++)
            step(4'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4 == 0) ? 32'h8000_0000 ^ 32'($urandom % 3) : 32'($urandom),
                 ($urandom % 4 == 0) ? 32'($urandom % 3) : 32'($urandom));
        step(4'hE, 1'b0, 1'b0, 32'h0, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule